// File: doc/BRIEF.md
# QPSK Dibit Carrier-Phase Selector

This block holds the digital timing and symbol mapping of a four-phase modulator. It gets a one-clock pulse on every edge of a 2400 Hz timing reference, so the pulses come at 4800 per second. Each pulse moves a quarter-cycle counter forward, and four pulses make one carrier cycle. The carrier therefore runs at half the reference, 1200 Hz. Two carrier cycles make one symbol, which gives 600 baud.

Serial data arrives at 1200 bits per second, one bit per carrier cycle. The block takes a bit at the end of each carrier cycle and tells the source when it does so. It pairs the bits into dibits: the first bit of the pair is the in-phase bit and the second is the quadrature bit. Once per symbol it updates a 2-bit select code for an external four-way phase multiplexer and pulses a strobe. The select code always changes at the start of a carrier cycle.

When the square-wave option is enabled, the block also drives a digital square carrier at the selected phase. The multiplexer, the analog filters and the pilot summing lie outside the block.

Top module: `qpsk_phase_sel`

## Requirements
- R1: While rst_n is low, the outputs are phaseSel = 00, symStrobe = 0 and bitTake = 0, and carrierSq = 1. The quarter counter and the pair register are cleared.
- R2: bitTake is high, in the same cycle, on the 4th, 8th, 12th and every further multiple-of-four edgeTick since reset. It is low in every other cycle.
- R3: phaseSel bit 0 equals the serData value taken at the first bitTake of a pair (I). Bit 1 equals the value taken at the second bitTake (Q). The new code appears one clock after the edgeTick that takes Q.
- R4: phaseSel changes only in a cycle where symStrobe is high.
- R5: symStrobe is high for exactly one clock once per symbol, in the cycle the new phaseSel appears. This happens even when the code value does not change.
- R6: serData has no effect in any cycle where bitTake is low.
- R7: With phaseSel = 00, carrierSq is high in quarters 0 and 3 of each carrier cycle and low in quarters 1 and 2. The quarter index is the count of edgeTicks since the last carrier-cycle start, modulo 4.
- R8: Each phaseSel value adds a fixed quarter offset before the R7 rule is applied. The offsets are 00 → 0 (+cos), 01 → 3 (+sin), 10 → 2 (−cos) and 11 → 1 (−sin).
- R9: In a cycle without edgeTick, the next clock leaves phaseSel and carrierSq unchanged and symStrobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edgeTick | input | 1 | One-clock pulse per edge of the 2400 Hz reference |
| serData | input | 1 | Serial data bit, 1200 bit/s |
| bitTake | output | 1 | High in the cycle serData is taken |
| phaseSel | output | 2 | Select code {Q,I} for the phase multiplexer |
| symStrobe | output | 1 | One-clock pulse when a new select code takes effect |
| carrierSq | output | 1 | Square carrier at the selected phase |

## Verification
bitTake is combinational on edgeTick and the quarter count, so it is due in the same cycle as the tick. phaseSel and symStrobe are due one clock after the tick that takes the Q bit. carrierSq follows the registered quarter count and code, so it moves one clock after any tick. The bench drives inputs at the falling edge and compares all four outputs 1 ns later with its model. It advances the model only at the following rising edge, so every expected value lines up with the register stage that produces it.

// File: rtl/qpsk_sel_pkg.sv
package qpsk_sel_pkg;

  localparam int SEL_W = 2;

  typedef logic [SEL_W-1:0] sel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeI;   // first bit of the pair is sampled
    logic takeQ;   // second bit sampled, code is reloaded
  } ctl_t;

  // quarter-cycle offset for a {Q,I} code: +cos, +sin, -cos, -sin
  function automatic sel_t phaseOffset(input sel_t code);
    return sel_t'(0) - code;
  endfunction

endpackage

// File: rtl/qpsk_sel_ctrl.sv
module qpsk_sel_ctrl
  import qpsk_sel_pkg::*;
#(
  parameter int QUARTERS = 4,
  parameter int CYCLES_PER_SYM = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        edgeTick,
  output ctl_t                        ctl,
  output logic [$clog2(QUARTERS)-1:0] quarter,
  output logic                        bitTake
);

  localparam int STEPS  = QUARTERS * CYCLES_PER_SYM;
  localparam int STEP_W = $clog2(STEPS);
  localparam int QW     = $clog2(QUARTERS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
  localparam logic [QW-1:0]     LAST_QTR  = QW'(QUARTERS - 1);

  logic [STEP_W-1:0] stepCnt;
  logic              cycleEnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepCnt <= '0;
    end else if (edgeTick) begin
      stepCnt <= (stepCnt == LAST_STEP) ? '0 : stepCnt + 1'b1;
    end
  end

  assign quarter  = stepCnt[QW-1:0];
  assign cycleEnd = (quarter == LAST_QTR);

  always_comb begin
    ctl.takeQ = edgeTick && (stepCnt == LAST_STEP);
    ctl.takeI = edgeTick && cycleEnd && (stepCnt != LAST_STEP);
  end

  assign bitTake = ctl.takeI | ctl.takeQ;

endmodule

// File: rtl/qpsk_sel_dp.sv
module qpsk_sel_dp
  import qpsk_sel_pkg::*;
#(
  parameter int QW = 2,
  parameter bit SQUARE_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [QW-1:0] quarter,
  input  logic          serData,
  output sel_t          phaseSel,
  output logic          symStrobe,
  output logic          carrierSq
);

  logic iHold;
  sel_t selReg;
  logic strobeReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iHold     <= 1'b0;
      selReg    <= '0;
      strobeReg <= 1'b0;
    end else begin
      strobeReg <= ctl.takeQ;
      if (ctl.takeI) iHold <= serData;
      if (ctl.takeQ) selReg <= {serData, iHold};
    end
  end

  assign phaseSel  = selReg;
  assign symStrobe = strobeReg;

  generate
    if (SQUARE_EN) begin : g_square
      logic [QW-1:0] shifted;
      always_comb begin
        shifted   = quarter + QW'(phaseOffset(selReg));
        // cosine-like square: high in the first and last quarter
        carrierSq = (shifted[QW-1] == shifted[QW-2]);
      end
    end else begin : g_nosquare
      logic unusedQ;
      assign unusedQ   = ^quarter;
      assign carrierSq = 1'b1 & ~(unusedQ & 1'b0);
    end
  endgenerate

endmodule

// File: rtl/qpsk_phase_sel.sv
module qpsk_phase_sel
  import qpsk_sel_pkg::*;
#(
  parameter int QUARTERS = 4,
  parameter int CYCLES_PER_SYM = 2,
  parameter bit SQUARE_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       edgeTick,
  input  logic       serData,
  output logic       bitTake,
  output logic [1:0] phaseSel,
  output logic       symStrobe,
  output logic       carrierSq
);

  localparam int QW = $clog2(QUARTERS);

  ctl_t          ctl;
  logic [QW-1:0] quarter;

  qpsk_sel_ctrl #(
    .QUARTERS(QUARTERS),
    .CYCLES_PER_SYM(CYCLES_PER_SYM)
  ) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .edgeTick(edgeTick),
    .ctl(ctl),
    .quarter(quarter),
    .bitTake(bitTake)
  );

  qpsk_sel_dp #(
    .QW(QW),
    .SQUARE_EN(SQUARE_EN)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .ctl(ctl),
    .quarter(quarter),
    .serData(serData),
    .phaseSel(phaseSel),
    .symStrobe(symStrobe),
    .carrierSq(carrierSq)
  );

endmodule

// File: rtl/qpsk_phase_sel_chk.sv
module qpsk_phase_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       edgeTick,
  input logic       serData,
  input logic       bitTake,
  input logic [1:0] phaseSel,
  input logic       symStrobe,
  input logic       carrierSq
);

  AST_TAKE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bitTake |-> edgeTick); // R2

  AST_Q_BIT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    symStrobe |-> (phaseSel[1] == $past(serData)) && $past(bitTake)); // R3

  AST_SEL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseSel != $past(phaseSel)) |-> symStrobe); // R4

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    symStrobe |=> !symStrobe); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !edgeTick |=> $stable(phaseSel) && $stable(carrierSq) && !symStrobe); // R9

endmodule

bind qpsk_phase_sel qpsk_phase_sel_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .edgeTick(edgeTick),
  .serData(serData),
  .bitTake(bitTake),
  .phaseSel(phaseSel),
  .symStrobe(symStrobe),
  .carrierSq(carrierSq)
);

// File: tb/tb_qpsk_phase_sel.sv
`timescale 1ns/1ps
module tb_qpsk_phase_sel;

  logic clk = 1'b0;
  logic rst_n;
  logic edgeTick;
  logic serData;
  logic bitTake;
  logic [1:0] phaseSel;
  logic symStrobe;
  logic carrierSq;

  always #2 clk = ~clk;

  qpsk_phase_sel dut (
    .clk(clk),
    .rst_n(rst_n),
    .edgeTick(edgeTick),
    .serData(serData),
    .bitTake(bitTake),
    .phaseSel(phaseSel),
    .symStrobe(symStrobe),
    .carrierSq(carrierSq)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model
  int mCnt;
  logic mI;
  logic [1:0] mSel;
  logic mStr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expCarrier(input int cnt, input logic [1:0] s);
    int p;
    p = ((cnt % 4) + ((4 - int'(s)) % 4)) % 4;
    return (p == 0) || (p == 3);
  endfunction

  task automatic step(input logic tk, input logic d, input string tag);
    logic expTake;
    edgeTick = tk;
    serData  = d;
    #1;
    expTake = tk && (mCnt % 4 == 3);
    chk(bitTake === expTake, "R2 bitTake", int'(bitTake), int'(expTake));
    chk(phaseSel === mSel, {"R3 phaseSel ", tag}, int'(phaseSel), int'(mSel));
    chk(symStrobe === mStr, {"R5 symStrobe ", tag}, int'(symStrobe), int'(mStr));
    chk(carrierSq === expCarrier(mCnt, mSel), (mSel == 2'b00) ? "R7 carrier" : "R8 carrier",
        int'(carrierSq), int'(expCarrier(mCnt, mSel)));
    @(posedge clk);
    mStr = 1'b0;
    if (tk) begin
      if (mCnt == 3) mI = d;
      if (mCnt == 7) begin
        mSel = {d, mI};
        mStr = 1'b1;
      end
      mCnt = (mCnt + 1) % 8;
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    edgeTick = 1'b0;
    #1;
    mCnt = 0; mI = 1'b0; mSel = 2'b00; mStr = 1'b0;
    chk(phaseSel === 2'b00, "R1 phaseSel", int'(phaseSel), 0);
    chk(symStrobe === 1'b0, "R1 symStrobe", int'(symStrobe), 0);
    chk(bitTake === 1'b0, "R1 bitTake", int'(bitTake), 0);
    chk(carrierSq === 1'b1, "R1 carrierSq", int'(carrierSq), 1);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one full symbol starting at quarter count 0
  task automatic runSymbol(input logic [1:0] dib, input int gap, input bit noisy, input string tag);
    for (int t = 0; t < 8; t++) begin
      logic d;
      for (int g = 0; g < gap; g++) step(1'b0, noisy ? 1'($urandom % 2) : 1'b0, tag);
      if (t == 3)      d = dib[0];
      else if (t == 7) d = dib[1];
      else             d = noisy ? 1'($urandom % 2) : 1'b0;
      step(1'b1, d, tag);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    edgeTick = 1'b0;
    serData = 1'b0;
    @(negedge clk);
    doReset();

    // R9: no ticks, data toggling
    for (int i = 0; i < 6; i++) step(1'b0, 1'(i % 2), "R9");

    // R3 / R8: each code in turn
    runSymbol(2'b00, 2, 1'b0, "R3");
    runSymbol(2'b01, 2, 1'b0, "R3");
    runSymbol(2'b10, 2, 1'b0, "R3");
    runSymbol(2'b11, 2, 1'b0, "R3");
    // R5: repeated code still strobes
    runSymbol(2'b01, 1, 1'b0, "R5");
    runSymbol(2'b01, 1, 1'b0, "R5");

    // R6: data noise outside sampling cycles
    for (int s = 0; s < 6; s++) runSymbol(2'($urandom % 4), 3, 1'b1, "R6");

    // R4: back-to-back ticks
    for (int s = 0; s < 6; s++) runSymbol(2'($urandom % 4), 0, 1'b1, "R4");

    // R9: long quiet gap mid-symbol
    for (int t = 0; t < 5; t++) step(1'b1, 1'b1, "R9");
    for (int i = 0; i < 10; i++) step(1'b0, 1'(i % 2), "R9");
    for (int t = 5; t < 8; t++) step(1'b1, 1'b0, "R9");

    // R1: reset in the middle of a symbol
    for (int t = 0; t < 5; t++) step(1'b1, 1'b1, "R1");
    doReset();
    runSymbol(2'b10, 1, 1'b1, "R1");

    // random traffic
    for (int s = 0; s < 30; s++) runSymbol(2'($urandom % 4), int'($urandom % 4), 1'b1, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule